// File: doc/BRIEF.md
# Completion Interrupt Coalescer

This block sits beside a packet DMA engine and turns a stream of per-descriptor completion strobes into a small number of interrupts. It keeps two independent directions, receive-done and transmit-done. Each direction counts completed descriptors that are still pending. It raises a queue-in event as soon as the pending count reaches a programmed threshold. If descriptors are pending but the threshold is never reached, it raises a timeout event once a programmed number of cycles has passed since the most recent completion.

Events are held in a raw status register, which software clears by writing ones to it. An enable register selects which raw bits may interrupt. The masked status is the raw status ANDed with the enable register, and the single interrupt output is the OR of the masked bits. Software reads and writes the registers through a simple synchronous register port: one write strobe, a 3-bit word address, 32-bit write data and combinational read data.

Top module: `cmpl_irq_coalescer`

## Requirements
- R1: After reset the raw status and enable registers read 0 and `irq_o` is low. The threshold register reads 0x00010001, the receive timeout reads 0x10000 and the transmit timeout reads 0x50000.
- R2: The register map by word address is: 0 raw status, 1 enable, 2 masked status, 3 thresholds, 4 receive timeout, 5 transmit timeout. In the threshold register, the receive threshold occupies bits 15:0 and the transmit threshold starts at bit 16. Both read back as written.
- R3: A strobe that brings a direction's pending count up to its threshold sets that direction's queue-in bit in the clock edge that samples the strobe. The receive queue-in bit is bit 17 and the transmit queue-in bit is bit 19. The pending count then returns to zero, so exactly threshold strobes are needed for the next queue-in event.
- R4: A threshold of 1 raises queue-in on every strobe. A threshold of 0 behaves as 1.
- R5: With a nonzero pending count, a nonzero timeout T and no further strobe, the timeout bit is set exactly T clock edges after the edge that sampled the last strobe. The receive timeout bit is bit 28 and the transmit timeout bit is bit 29. The pending count then returns to zero, so the timeout does not fire again.
- R6: Every new strobe restarts its direction's timeout count from zero.
- R7: A timeout value of 0 disables the timeout. Pending descriptors then wait indefinitely for the count threshold.
- R8: Writing to raw status clears every bit written as 1 and leaves every bit written as 0 unchanged. Writing all ones clears every pending event.
- R9: If a new event and a write-one-to-clear hit the same raw bit in the same cycle, the bit stays set.
- R10: Masked status reads raw AND enable, and `irq_o` is high exactly when the masked status is nonzero. `irq_o` follows raw and enable changes with no added cycle.
- R11: The two directions are independent. Strobes on one direction never set the other direction's bits.
- R12: Writes to the masked status address change nothing. Raw status and enable bits other than 17, 19, 28 and 29 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_done_i | input | 1 | One-cycle strobe per receive-done descriptor |
| tx_done_i | input | 1 | One-cycle strobe per transmit-done descriptor |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| irq_o | output | 1 | Interrupt, OR of masked status |

## Verification
On every cycle, the assertions check four things. A queue-in event always lands in the raw register despite a simultaneous clear. A clear without a competing event always removes the bit. A non-firing strobe advances the pending count by exactly one. The timeout counter sits at zero whenever nothing is pending. The assertions also check that a zero enable keeps the interrupt low.

Only the bench scenarios can show the exact cycle on which the count threshold and the timeout fire, across a sweep of thresholds and timeout values. The same applies to the restart of the timeout on new strobes, the disabling of the timeout with a zero value, and the exhaustive enable-by-raw interrupt table.

// File: rtl/cic_pkg.sv
package cic_pkg;
   localparam int STAT_W    = 32;
   localparam int RX_IN_POS = 17;
   localparam int TX_IN_POS = 19;
   localparam int RX_TO_POS = 28;
   localparam int TX_TO_POS = 29;
   localparam int N_DIR     = 2;
   localparam logic [STAT_W-1:0] VALID_MASK =
      (32'd1 << RX_IN_POS) | (32'd1 << TX_IN_POS) |
      (32'd1 << RX_TO_POS) | (32'd1 << TX_TO_POS);

   typedef enum logic [2:0] {
      A_RAW    = 3'd0,
      A_ENABLE = 3'd1,
      A_MASKED = 3'd2,
      A_THRESH = 3'd3,
      A_RX_TMO = 3'd4,
      A_TX_TMO = 3'd5
   } cic_addr_e;

   function automatic int in_pos(input int dir);
      return (dir == 0) ? RX_IN_POS : TX_IN_POS;
   endfunction

   function automatic int to_pos(input int dir);
      return (dir == 0) ? RX_TO_POS : TX_TO_POS;
   endfunction
endpackage

// File: rtl/cic_dir_tracker.sv
module cic_dir_tracker #(
   parameter int CNT_W = 16,
   parameter int TO_W  = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ev_i,
   input  logic [CNT_W-1:0] thr_i,
   input  logic [TO_W-1:0]  tmo_i,
   output logic             fire_in_o,
   output logic             fire_to_o
);
   logic [CNT_W-1:0] cnt_q;
   logic [TO_W-1:0]  timer_q;
   logic [CNT_W:0]   cnt_inc;
   logic [CNT_W:0]   thr_eff;
   logic             pending;
   logic             tmo_on;

   assign cnt_inc   = {1'b0, cnt_q} + (CNT_W+1)'(1);
   assign thr_eff   = (thr_i == '0) ? (CNT_W+1)'(1) : {1'b0, thr_i};
   assign pending   = (cnt_q != '0);
   assign tmo_on    = (tmo_i != '0);
   assign fire_in_o = ev_i && (cnt_inc >= thr_eff);
   assign fire_to_o = !ev_i && pending && tmo_on && (timer_q >= tmo_i - TO_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         timer_q <= '0;
      end else if (ev_i) begin
         cnt_q   <= fire_in_o ? '0 : cnt_inc[CNT_W-1:0];
         timer_q <= '0;
      end else if (pending && tmo_on) begin
         if (fire_to_o) begin
            cnt_q   <= '0;
            timer_q <= '0;
         end else begin
            timer_q <= timer_q + TO_W'(1);
         end
      end
   end

   AST_TIMER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '0) |-> (timer_q == '0));                                   // R5
   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_i && !fire_in_o) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));       // R3
endmodule

// File: rtl/cic_irq_out.sv
module cic_irq_out #(
   parameter int  STAT_W  = 32,
   parameter bit  IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STAT_W-1:0] masked_i,
   input  logic [STAT_W-1:0] enable_i,
   output logic              irq_o
);
   generate
      if (IRQ_REG) begin : g_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= |masked_i;
         end
         assign irq_o = irq_q;
      end else begin : g_comb
         assign irq_o = |masked_i;
         AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
            (enable_i == '0) |-> !irq_o);                                   // R10
      end
   endgenerate
endmodule

// File: rtl/cmpl_irq_coalescer.sv
module cmpl_irq_coalescer
   import cic_pkg::*;
#(
   parameter int          CNT_W       = 16,
   parameter int          TO_W        = 24,
   parameter logic [15:0] DEF_RX_THR  = 16'd1,
   parameter logic [15:0] DEF_TX_THR  = 16'd1,
   parameter logic [31:0] DEF_RX_TMO  = 32'h0001_0000,
   parameter logic [31:0] DEF_TX_TMO  = 32'h0005_0000,
   parameter bit          IRQ_REG     = 1'b0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        rx_done_i,
   input  logic        tx_done_i,
   input  logic        reg_we_i,
   input  logic [2:0]  reg_addr_i,
   input  logic [31:0] reg_wdata_i,
   output logic [31:0] reg_rdata_o,
   output logic        irq_o
);
   localparam int HALF = 16;

   if (CNT_W < 1 || CNT_W > HALF) begin : g_bad_cnt
      $error("CNT_W must fit in a half-word");
   end
   if (TO_W < 1 || TO_W > 32) begin : g_bad_to
      $error("TO_W must be 1..32");
   end

   logic [CNT_W-1:0]  thr_q [N_DIR];
   logic [TO_W-1:0]   tmo_q [N_DIR];
   logic [N_DIR-1:0]  ev;
   logic [N_DIR-1:0]  fire_in;
   logic [N_DIR-1:0]  fire_to;
   logic [STAT_W-1:0] raw_q, en_q, masked, set_vec, clr_vec;
   logic              wr_raw;

   assign ev     = {tx_done_i, rx_done_i};
   assign wr_raw = reg_we_i && (reg_addr_i == A_RAW);

   for (genvar g = 0; g < N_DIR; g++) begin : g_dir
      cic_dir_tracker #(.CNT_W(CNT_W), .TO_W(TO_W)) u_trk (
         .clk       (clk),
         .rst_n     (rst_n),
         .ev_i      (ev[g]),
         .thr_i     (thr_q[g]),
         .tmo_i     (tmo_q[g]),
         .fire_in_o (fire_in[g]),
         .fire_to_o (fire_to[g])
      );
   end

   always_comb begin
      set_vec = '0;
      for (int d = 0; d < N_DIR; d++) begin
         set_vec[in_pos(d)] = fire_in[d];
         set_vec[to_pos(d)] = fire_to[d];
      end
      clr_vec = wr_raw ? reg_wdata_i : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         raw_q    <= '0;
         en_q     <= '0;
         thr_q[0] <= DEF_RX_THR[CNT_W-1:0];
         thr_q[1] <= DEF_TX_THR[CNT_W-1:0];
         tmo_q[0] <= DEF_RX_TMO[TO_W-1:0];
         tmo_q[1] <= DEF_TX_TMO[TO_W-1:0];
      end else begin
         raw_q <= ((raw_q & ~clr_vec) | set_vec) & VALID_MASK;
         if (reg_we_i) begin
            case (reg_addr_i)
               A_ENABLE: en_q <= reg_wdata_i & VALID_MASK;
               A_THRESH: begin
                  thr_q[0] <= reg_wdata_i[CNT_W-1:0];
                  thr_q[1] <= reg_wdata_i[HALF +: CNT_W];
               end
               A_RX_TMO: tmo_q[0] <= reg_wdata_i[TO_W-1:0];
               A_TX_TMO: tmo_q[1] <= reg_wdata_i[TO_W-1:0];
               default: ;
            endcase
         end
      end
   end

   assign masked = raw_q & en_q;

   always_comb begin
      reg_rdata_o = '0;
      case (reg_addr_i)
         A_RAW:    reg_rdata_o = raw_q;
         A_ENABLE: reg_rdata_o = en_q;
         A_MASKED: reg_rdata_o = masked;
         A_THRESH: begin
            reg_rdata_o[CNT_W-1:0]     = thr_q[0];
            reg_rdata_o[HALF +: CNT_W] = thr_q[1];
         end
         A_RX_TMO: reg_rdata_o[TO_W-1:0] = tmo_q[0];
         A_TX_TMO: reg_rdata_o[TO_W-1:0] = tmo_q[1];
         default:  reg_rdata_o = '0;
      endcase
   end

   cic_irq_out #(.STAT_W(STAT_W), .IRQ_REG(IRQ_REG)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .masked_i (masked),
      .enable_i (en_q),
      .irq_o    (irq_o)
   );

   AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      fire_in[0] |=> raw_q[RX_IN_POS]);                                     // R9
   AST_TX_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      fire_to[1] |=> raw_q[TX_TO_POS]);                                     // R9
   AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_raw && reg_wdata_i[RX_TO_POS] && !fire_to[0]) |=> !raw_q[RX_TO_POS]); // R8
   AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ((raw_q | en_q) & ~VALID_MASK) == '0);                                // R12
endmodule

// File: tb/cmpl_irq_coalescer_bench.sv
module cmpl_irq_coalescer_bench;
   localparam int RXI = 17, TXI = 19, RXT = 28, TXT = 29;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_done = 1'b0, tx_done = 1'b0;
   logic        we = 1'b0;
   logic [2:0]  addr = 3'd0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;
   int          checks = 0, errors = 0;
   logic [31:0] v;

   always #4 clk = ~clk;

   cmpl_irq_coalescer u_cmpl_irq_coalescer (
      .clk(clk), .rst_n(rst_n), .rx_done_i(rx_done), .tx_done_i(tx_done),
      .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
      .reg_rdata_o(rdata), .irq_o(irq)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk); we = 1'b1; addr = a; wdata = d;
      @(negedge clk); we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      addr = a; #1; d = rdata;
   endtask

   task automatic strobe(input logic r, input logic t);
      @(negedge clk); rx_done = r; tx_done = t;
      @(negedge clk); rx_done = 1'b0; tx_done = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic raw_is(input string req, input logic [31:0] exp);
      logic [31:0] r;
      rd(3'd0, r);
      chk(req, r, exp);
   endtask

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R1 reset state
      rd(3'd0, v); chk("R1 raw", v, 0);
      rd(3'd1, v); chk("R1 enable", v, 0);
      chk("R1 irq", {31'd0, irq}, 0);
      rd(3'd3, v); chk("R1 thresh", v, 32'h0001_0001);
      rd(3'd4, v); chk("R1 rx tmo", v, 32'h0001_0000);
      rd(3'd5, v); chk("R1 tx tmo", v, 32'h0005_0000);

      // R2 readback
      wr(3'd3, 32'h0007_0005); rd(3'd3, v); chk("R2 thresh", v, 32'h0007_0005);
      wr(3'd4, 32'd0); rd(3'd4, v); chk("R2 rx tmo", v, 0);
      wr(3'd5, 32'd0); rd(3'd5, v); chk("R2 tx tmo", v, 0);

      // R3 / R4 / R11 threshold sweep, both directions
      for (int d = 0; d < 2; d++) begin
         for (int thr = 0; thr <= 5; thr++) begin
            int eff;
            logic [31:0] bit_v;
            eff = (thr == 0) ? 1 : thr;
            bit_v = (d == 0) ? (32'd1 << RXI) : (32'd1 << TXI);
            wr(3'd3, (d == 0) ? {16'd100, 16'(thr)} : {16'(thr), 16'd100});
            for (int k = 0; k < eff - 1; k++) strobe(d == 0, d == 1);
            raw_is("R3 below threshold", 0);
            strobe(d == 0, d == 1);
            raw_is("R3 R4 R11 at threshold", bit_v);
            wr(3'd0, bit_v);
            raw_is("R8 cleared", 0);
            for (int k = 0; k < eff - 1; k++) strobe(d == 0, d == 1);
            raw_is("R3 count restarted", 0);
            strobe(d == 0, d == 1);
            raw_is("R3 second batch", bit_v);
            wr(3'd0, 32'hFFFF_FFFF);
         end
      end

      // R5 timeout sweep
      wr(3'd3, {16'd100, 16'd100});
      for (int d = 0; d < 2; d++) begin
         for (int t = 1; t <= 6; t++) begin
            logic [31:0] bit_v;
            bit_v = (d == 0) ? (32'd1 << RXT) : (32'd1 << TXT);
            wr((d == 0) ? 3'd4 : 3'd5, t);
            strobe(d == 0, d == 1);
            idle(t - 1);
            raw_is("R5 before timeout", 0);
            idle(1);
            raw_is("R5 R11 timeout edge", bit_v);
            wr(3'd0, bit_v);
            idle(t + 2);
            raw_is("R5 no refire", 0);
         end
         wr((d == 0) ? 3'd4 : 3'd5, 0);
      end

      // R6 restart on new strobe
      wr(3'd4, 4);
      strobe(1, 0);
      idle(2);
      strobe(1, 0);
      idle(3);
      raw_is("R6 restarted", 0);
      idle(1);
      raw_is("R6 fired after restart", 32'd1 << RXT);
      wr(3'd0, 32'hFFFF_FFFF);

      // R7 zero timeout disables
      wr(3'd4, 0);
      strobe(1, 0);
      idle(20);
      raw_is("R7 no timeout", 0);
      wr(3'd3, {16'd100, 16'd2});
      strobe(1, 0);
      raw_is("R7 pending kept", 32'd1 << RXI);
      wr(3'd0, 32'hFFFF_FFFF);

      // Build all four bits
      wr(3'd3, {16'd100, 16'd100});
      wr(3'd4, 2); wr(3'd5, 2);
      strobe(1, 1);
      idle(2);
      wr(3'd4, 0); wr(3'd5, 0);
      wr(3'd3, {16'd1, 16'd1});
      strobe(1, 1);
      raw_is("R3 R5 all bits", 32'h300A_0000);

      // R10 exhaustive enable table
      for (int e = 0; e < 16; e++) begin
         logic [31:0] en;
         en = (e[0] ? 32'd1 << RXI : 0) | (e[1] ? 32'd1 << TXI : 0) |
              (e[2] ? 32'd1 << RXT : 0) | (e[3] ? 32'd1 << TXT : 0);
         wr(3'd1, en | 32'h0000_FFFF);
         rd(3'd1, v); chk("R12 enable unused bits", v, en);
         rd(3'd2, v); chk("R10 masked", v, en & 32'h300A_0000);
         chk("R10 irq", {31'd0, irq}, {31'd0, e != 0});
      end

      // R12 masked write ignored
      wr(3'd2, 32'd0);
      raw_is("R12 masked write", 32'h300A_0000);

      // R8 partial clear
      wr(3'd0, 32'd1 << RXT);
      raw_is("R8 partial clear", 32'h200A_0000);

      // R9 event beats clear
      @(negedge clk);
      rx_done = 1'b1; we = 1'b1; addr = 3'd0; wdata = 32'hFFFF_FFFF;
      @(negedge clk);
      rx_done = 1'b0; we = 1'b0;
      raw_is("R9 set wins", 32'd1 << RXI);
      chk("R10 irq still", {31'd0, irq}, 1);

      wr(3'd0, 32'hFFFF_FFFF);
      raw_is("R8 all ones", 0);
      chk("R10 irq low", {31'd0, irq}, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule